// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Role-Dependent Pin Routing

This block moves one byte at a time over a four-wire synchronous serial bus. The four wires are a serial clock, two data lines (called line A and line B here) and an active-low select. A single shift register carries each byte. It is loaded from a transmit holding register and, once the byte is complete, unloads into a receive holding register. Three status flags describe the state of the block: transmit-holding-empty, receive-full and overrun.

Two mode bits decide how the shift register connects to the data lines. In standard mode the role matters. A master sends on line A and listens on line B. A slave does the reverse: it sends on line B and listens on line A. In bidirectional mode both directions share line A, and only one direction can be active at a time. As master, the block generates the serial clock and drives the select line. As slave, it takes both from the bus through synchronisers.

Software enables transmit and receive separately. The mode bits can only be changed while both enables are off.

Top module: `sync_serial_unit`

## Requirements
- R1: After reset: tdre=1, rdrf=0, ovr=0, sck_o=1, csn_o=1, a_oe=0, b_oe=0, sck_oe=0 and csn_oe=0. The mode after reset is standard slave.
- R2: In standard master mode (mode_bidir=0, mode_master=1), transmitted bits appear on a_o with a_oe=1 while a byte is in progress. Received bits are taken from b_i. b_oe stays 0.
- R3: In standard slave mode (mode_bidir=0, mode_master=0), transmitted bits appear on b_o with b_oe=1 while the select is low. Received bits are taken from a_i. sck_oe=0 and csn_oe=0.
- R4: In bidirectional mode (mode_bidir=1), transmit and receive both use line A, whatever the role. b_oe is never 1 in this mode.
- R5: In bidirectional mode with both enables set, only transmit runs: no byte is captured and rdrf does not change. a_oe is 1 only while a transmit byte is in progress. At all other times it is 0.
- R6: A byte is 8 bits, most significant bit first. Data is sampled on the rising clock edge and changed on the falling edge. As master, sck idles high and stays in each level for HALF_DIV clock cycles.
- R7: As master, csn_o is low at every rising sck edge of a byte and returns high after the byte.
- R8: Clearing the transmit enable sets tdre to 1. A write to the transmit holding register while transmit is disabled leaves tdre at 1.
- R9: Clearing the receive enable leaves rdrf, ovr and rdr_q unchanged.
- R10: A mode write is ignored while either enable is set.
- R11: If a received byte completes while rdrf=1, ovr becomes 1 and rdr_q keeps its previous value.
- R12: A read strobe clears rdrf. A transmit-holding write with transmit enabled clears tdre. As master, a byte starts when transmit is active and tdre=0. With receive only, a byte starts whenever rdrf=0, and no byte starts while rdrf=1.
- R13: An ovr_clr strobe clears ovr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode write strobe |
| mode_bidir | input | 1 | Mode value: 1 selects the shared-line mode |
| mode_master | input | 1 | Mode value: 1 selects the master role |
| en_we | input | 1 | Enable write strobe |
| en_tx | input | 1 | Transmit enable value |
| en_rx | input | 1 | Receive enable value |
| tdr_we | input | 1 | Transmit holding register write strobe |
| tdr_wdata | input | DATA_W | Transmit holding register write data |
| rdr_re | input | 1 | Receive holding register read strobe |
| ovr_clr | input | 1 | Overrun flag clear strobe |
| rdr_q | output | DATA_W | Receive holding register |
| tdre | output | 1 | Transmit holding register empty |
| rdrf | output | 1 | Receive holding register full |
| ovr | output | 1 | Overrun flag |
| sck_i | input | 1 | Serial clock from the bus (slave) |
| sck_o | output | 1 | Serial clock driven (master) |
| sck_oe | output | 1 | Serial clock output enable |
| csn_i | input | 1 | Select from the bus, active low (slave) |
| csn_o | output | 1 | Select driven, active low (master) |
| csn_oe | output | 1 | Select output enable |
| a_i | input | 1 | Data line A input |
| a_o | output | 1 | Data line A output value |
| a_oe | output | 1 | Data line A output enable |
| b_i | input | 1 | Data line B input |
| b_o | output | 1 | Data line B output value |
| b_oe | output | 1 | Data line B output enable |

## Verification
The bench builds the block with DATA_W=8 and HALF_DIV=2. The short half period keeps each master byte to about forty cycles, so random bytes can be run in every role and line combination well inside the run budget. The bench checks the serial clock period against 2*HALF_DIV cycles. Because the bench drives the slave clock much more slowly than the synchroniser delay, slave-mode data sampling and shifting are checked without any race against that delay.

// File: rtl/ssu_pkg.sv
`timescale 1ns/1ps
package ssu_pkg;

  typedef struct packed {
    logic bidir;   // 1: both directions on line A
    logic master;  // 1: block drives clock and select
  } ssu_mode_t;

  // Transmit goes to line B only for a standard-mode slave.
  function automatic logic tx_uses_b(input ssu_mode_t m);
    return !m.bidir && !m.master;
  endfunction

  // Receive comes from line B only for a standard-mode master.
  function automatic logic rx_uses_b(input ssu_mode_t m);
    return !m.bidir && m.master;
  endfunction

  // On the shared line, transmit wins when both directions are enabled.
  function automatic logic rx_permitted(input ssu_mode_t m, input logic te, input logic re);
    return re && !(m.bidir && te);
  endfunction

endpackage

// File: rtl/ssu_pinmux.sv
`timescale 1ns/1ps
module ssu_pinmux
  import ssu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ssu_mode_t mode,
  input  logic      tx_act,
  input  logic      sel,
  input  logic      dout,
  input  logic      a_i,
  input  logic      b_i,
  output logic      a_o,
  output logic      a_oe,
  output logic      b_o,
  output logic      b_oe,
  output logic      din_raw
);

  logic drive_en;
  logic on_b;

  assign drive_en = tx_act && sel;
  assign on_b     = tx_uses_b(mode);

  always_comb begin
    a_o     = dout;
    b_o     = dout;
    a_oe    = drive_en && !on_b;
    b_oe    = drive_en && on_b;
    din_raw = rx_uses_b(mode) ? b_i : a_i;
  end

  AST_SHARED_LINE_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode.bidir |-> !b_oe);  // R4
  AST_ONE_LINE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe));  // R2
  AST_NO_DRIVE_WITHOUT_TX: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_act |-> !(a_oe || b_oe));  // R5

endmodule

// File: rtl/ssu_clkgen.sv
`timescale 1ns/1ps
module ssu_clkgen #(
  parameter int HALF_DIV = 4,
  parameter int DATA_W   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic start,
  input  logic sck_i,
  input  logic csn_i,
  input  logic din_raw,
  output logic sck_o,
  output logic csn_o,
  output logic busy,
  output logic rise_evt,
  output logic fall_evt,
  output logic load_evt,
  output logic sel,
  output logic din_eff
);

  localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int RISE_W = $clog2(DATA_W + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [RISE_W-1:0] RISE_ALL = RISE_W'(DATA_W);

  // ---------------- master timing ----------------
  logic [DIV_W-1:0]  div_q;
  logic [RISE_W-1:0] rises_q;
  logic              sck_q, csn_q, busy_q;
  logic              tick, m_rise, m_fall, m_load;

  assign tick   = busy_q && (div_q == DIV_LAST);
  assign m_rise = tick && !sck_q;
  assign m_fall = tick && sck_q && (rises_q != RISE_ALL);
  assign m_load = master && start && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b1;
      csn_q   <= 1'b1;
      div_q   <= '0;
      rises_q <= '0;
    end else if (!busy_q) begin
      if (m_load) begin
        busy_q  <= 1'b1;
        csn_q   <= 1'b0;
        div_q   <= '0;
        rises_q <= '0;
      end
    end else if (tick) begin
      div_q <= '0;
      if (rises_q == RISE_ALL) begin
        busy_q <= 1'b0;
        csn_q  <= 1'b1;
      end else begin
        sck_q <= ~sck_q;
        if (!sck_q) rises_q <= rises_q + 1'b1;
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // ---------------- slave synchronisers ----------------
  logic [1:0] sck_sy, csn_sy, din_sy;
  logic       sck_d, csn_d;
  logic       s_rise, s_fall, s_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= 2'b11;
      csn_sy <= 2'b11;
      din_sy <= 2'b00;
      sck_d  <= 1'b1;
      csn_d  <= 1'b1;
    end else begin
      sck_sy <= {sck_sy[0], sck_i};
      csn_sy <= {csn_sy[0], csn_i};
      din_sy <= {din_sy[0], din_raw};
      sck_d  <= sck_sy[1];
      csn_d  <= csn_sy[1];
    end
  end

  assign s_rise = !csn_sy[1] && sck_sy[1] && !sck_d;
  assign s_fall = !csn_sy[1] && !sck_sy[1] && sck_d;
  assign s_load = csn_d && !csn_sy[1];

  always_comb begin
    sck_o    = sck_q;
    csn_o    = csn_q;
    busy     = busy_q;
    rise_evt = master ? m_rise : s_rise;
    fall_evt = master ? m_fall : s_fall;
    load_evt = master ? m_load : s_load;
    sel      = master ? busy_q : !csn_sy[1];
    din_eff  = master ? din_raw : din_sy[1];
  end

  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sck_o);  // R6
  AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !csn_o);  // R7
  AST_SELECT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> csn_o && sck_o);  // R7

endmodule

// File: rtl/ssu_shifter.sv
`timescale 1ns/1ps
module ssu_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  input  logic [DATA_W-1:0] load_data,
  output logic              dout,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int BC_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(DATA_W - 1);

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] s, input logic b);
    return {s[DATA_W-2:0], b};
  endfunction

  logic [DATA_W-1:0] sh_q;
  logic [BC_W-1:0]   bit_q;
  logic              dout_q;

  assign done    = rise && (bit_q == BIT_LAST);
  assign rx_byte = shift_in(sh_q, din);
  assign dout    = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      dout_q <= 1'b0;
    end else if (load) begin
      sh_q   <= load_data;
      dout_q <= load_data[DATA_W-1];
      bit_q  <= '0;
    end else if (rise) begin
      sh_q  <= shift_in(sh_q, din);
      bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
    end else if (fall && (bit_q != '0)) begin
      dout_q <= sh_q[DATA_W-1];
    end
  end

  AST_FIRST_FALL_KEEPS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    fall && !load && !rise && (bit_q == '0) |=> $stable(dout_q));  // R6
  AST_OUT_STEADY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise && !load |=> $stable(dout_q));  // R6

endmodule

// File: rtl/ssu_regs.sv
`timescale 1ns/1ps
module ssu_regs
  import ssu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              mode_bidir,
  input  logic              mode_master,
  input  logic              en_we,
  input  logic              en_tx,
  input  logic              en_rx,
  input  logic              tdr_we,
  input  logic [DATA_W-1:0] tdr_wdata,
  input  logic              rdr_re,
  input  logic              ovr_clr,
  input  logic              busy,
  input  logic              load_evt,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output ssu_mode_t         mode,
  output logic              tx_act,
  output logic              rx_act,
  output logic              start,
  output logic [DATA_W-1:0] tdr,
  output logic [DATA_W-1:0] rdr,
  output logic              tdre,
  output logic              rdrf,
  output logic              ovr
);

  ssu_mode_t         mode_q;
  logic              tx_en_q, rx_en_q, tx_en_nxt;
  logic [DATA_W-1:0] tdr_q, rdr_q;
  logic              tdre_q, rdrf_q, ovr_q;
  logic              capture;

  assign tx_en_nxt = en_we ? en_tx : tx_en_q;
  assign tx_act    = tx_en_q;
  assign rx_act    = rx_permitted(mode_q, tx_en_q, rx_en_q);
  assign capture   = done && rx_act;
  assign start     = mode_q.master && !busy &&
                     (tx_act ? !tdre_q : (rx_act && !rdrf_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      tdr_q   <= '0;
      rdr_q   <= '0;
      tdre_q  <= 1'b1;
      rdrf_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (en_we) begin
        tx_en_q <= en_tx;
        rx_en_q <= en_rx;
      end
      if (mode_we && !tx_en_q && !rx_en_q)
        mode_q <= '{bidir: mode_bidir, master: mode_master};
      if (tdr_we) tdr_q <= tdr_wdata;
      if (!tx_en_nxt)              tdre_q <= 1'b1;
      else if (tdr_we)             tdre_q <= 1'b0;
      else if (load_evt && tx_act) tdre_q <= 1'b1;
      if (ovr_clr) ovr_q <= 1'b0;
      if (capture) begin
        if (rdrf_q) ovr_q <= 1'b1;
        else begin
          rdr_q  <= rx_byte;
          rdrf_q <= 1'b1;
        end
      end else if (rdr_re) begin
        rdrf_q <= 1'b0;
      end
    end
  end

  always_comb begin
    mode = mode_q;
    tdr  = tdr_q;
    rdr  = rdr_q;
    tdre = tdre_q;
    rdrf = rdrf_q;
    ovr  = ovr_q;
  end

  AST_TDRE_ON_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    en_we && !en_tx |=> tdre_q);  // R8
  AST_TDRE_HELD_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_q && !(en_we && en_tx) |=> tdre_q);  // R8
  AST_RX_OFF_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    en_we && !en_rx && !rdr_re && !ovr_clr && !capture |=> $stable(rdrf_q) && $stable(ovr_q) && $stable(rdr_q));  // R9
  AST_RDR_FROZEN_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_q |=> $stable(rdr_q));  // R9
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_q || rx_en_q) |=> $stable(mode_q));  // R10
  AST_OVERRUN_KEEPS_RDR: assert property (@(posedge clk) disable iff (!rst_n)
    done && rx_act && rdrf_q |=> ovr_q && $stable(rdr_q));  // R11
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy && mode_q.master);  // R12
  AST_SHARED_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.bidir |-> !(tx_act && rx_act));  // R5

endmodule

// File: rtl/sync_serial_unit.sv
`timescale 1ns/1ps
module sync_serial_unit
  import ssu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              mode_bidir,
  input  logic              mode_master,
  input  logic              en_we,
  input  logic              en_tx,
  input  logic              en_rx,
  input  logic              tdr_we,
  input  logic [DATA_W-1:0] tdr_wdata,
  input  logic              rdr_re,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rdr_q,
  output logic              tdre,
  output logic              rdrf,
  output logic              ovr,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              csn_i,
  output logic              csn_o,
  output logic              csn_oe,
  input  logic              a_i,
  output logic              a_o,
  output logic              a_oe,
  input  logic              b_i,
  output logic              b_o,
  output logic              b_oe
);

  ssu_mode_t         mode;
  logic              tx_act, rx_act, start, busy;
  logic              load_evt, rise_evt, fall_evt, done;
  logic              sel, dout, din_raw, din_eff;
  logic [DATA_W-1:0] tdr, rx_byte;

  ssu_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_bidir(mode_bidir), .mode_master(mode_master),
    .en_we(en_we), .en_tx(en_tx), .en_rx(en_rx),
    .tdr_we(tdr_we), .tdr_wdata(tdr_wdata), .rdr_re(rdr_re), .ovr_clr(ovr_clr),
    .busy(busy), .load_evt(load_evt), .done(done), .rx_byte(rx_byte),
    .mode(mode), .tx_act(tx_act), .rx_act(rx_act), .start(start),
    .tdr(tdr), .rdr(rdr_q), .tdre(tdre), .rdrf(rdrf), .ovr(ovr)
  );

  ssu_clkgen #(.HALF_DIV(HALF_DIV), .DATA_W(DATA_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .master(mode.master), .start(start),
    .sck_i(sck_i), .csn_i(csn_i), .din_raw(din_raw),
    .sck_o(sck_o), .csn_o(csn_o), .busy(busy),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .load_evt(load_evt),
    .sel(sel), .din_eff(din_eff)
  );

  ssu_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .rise(rise_evt), .fall(fall_evt),
    .din(din_eff), .load_data(tdr), .dout(dout), .done(done), .rx_byte(rx_byte)
  );

  ssu_pinmux u_pins (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tx_act(tx_act), .sel(sel), .dout(dout),
    .a_i(a_i), .b_i(b_i), .a_o(a_o), .a_oe(a_oe), .b_o(b_o), .b_oe(b_oe),
    .din_raw(din_raw)
  );

  assign sck_oe = mode.master;
  assign csn_oe = mode.master;

  AST_SLAVE_NO_BUS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.master |-> !sck_oe && !csn_oe && csn_o);  // R3

endmodule

// File: tb/sim_sync_serial_unit.sv
`timescale 1ns/1ps
module sim_sync_serial_unit;

  localparam int DW   = 8;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 0, mode_bidir = 0, mode_master = 0;
  logic en_we = 0, en_tx = 0, en_rx = 0;
  logic tdr_we = 0, rdr_re = 0, ovr_clr = 0;
  logic [DW-1:0] tdr_wdata = '0;
  logic [DW-1:0] rdr_q;
  logic tdre, rdrf, ovr;
  logic sck_i = 1'b1, csn_i = 1'b1, a_i = 1'b0, b_i = 1'b0;
  logic sck_o, sck_oe, csn_o, csn_oe, a_o, a_oe, b_o, b_oe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sync_serial_unit #(.DATA_W(DW), .HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_bidir(mode_bidir), .mode_master(mode_master),
    .en_we(en_we), .en_tx(en_tx), .en_rx(en_rx),
    .tdr_we(tdr_we), .tdr_wdata(tdr_wdata), .rdr_re(rdr_re), .ovr_clr(ovr_clr),
    .rdr_q(rdr_q), .tdre(tdre), .rdrf(rdrf), .ovr(ovr),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .csn_i(csn_i), .csn_o(csn_o), .csn_oe(csn_oe),
    .a_i(a_i), .a_o(a_o), .a_oe(a_oe), .b_i(b_i), .b_o(b_o), .b_oe(b_oe)
  );

  // Expected routing, from the requirements
  function automatic logic exp_tx_on_b(input logic bidir, input logic master);
    return (bidir == 1'b0) && (master == 1'b0);
  endfunction
  function automatic logic exp_rx_on_b(input logic bidir, input logic master);
    return (bidir == 1'b0) && (master == 1'b1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic bd, input logic ms);
    @(negedge clk); mode_we = 1; mode_bidir = bd; mode_master = ms;
    @(negedge clk); mode_we = 0;
  endtask
  task automatic wr_en(input logic t, input logic r);
    @(negedge clk); en_we = 1; en_tx = t; en_rx = r;
    @(negedge clk); en_we = 0;
  endtask
  task automatic wr_tdr(input logic [DW-1:0] d);
    @(negedge clk); tdr_we = 1; tdr_wdata = d;
    @(negedge clk); tdr_we = 0;
  endtask
  task automatic rd_rdr(output logic [DW-1:0] d);
    @(negedge clk); d = rdr_q; rdr_re = 1;
    @(negedge clk); rdr_re = 0;
  endtask
  task automatic clr_ovr();
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
  endtask

  // Bench acts as the far-end slave while the block is master.
  task automatic master_byte(input logic [DW-1:0] ext, input logic in_b, input logic out_b,
                             output logic [DW-1:0] seen, output logic cs_ok,
                             output logic oe_all, output logic oe_any, output int per);
    int t0;
    logic oe_now;
    seen = '0; cs_ok = 1; oe_all = 1; oe_any = 0; per = 0; t0 = 0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (in_b) b_i = ext[i]; else a_i = ext[i];
      @(posedge sck_o);
      @(negedge clk);
      if (i == DW - 1) t0 = cyc;
      if (i == DW - 2) per = cyc - t0;
      seen[i] = out_b ? b_o : a_o;
      if (csn_o !== 1'b0) cs_ok = 0;
      oe_now = out_b ? b_oe : a_oe;
      if (oe_now) oe_any = 1; else oe_all = 0;
      if (i > 0) begin
        @(negedge sck_o);
        @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
  endtask

  // Bench acts as the bus master while the block is slave.
  task automatic slave_byte(input logic [DW-1:0] ext, input logic in_b, input logic out_b,
                            output logic [DW-1:0] seen, output logic oe_any);
    seen = '0; oe_any = 0;
    csn_i = 0;
    repeat (6) @(negedge clk);
    for (int i = DW - 1; i >= 0; i--) begin
      sck_i = 0;
      if (in_b) b_i = ext[i]; else a_i = ext[i];
      repeat (6) @(negedge clk);
      seen[i] = out_b ? b_o : a_o;
      if (out_b ? b_oe : a_oe) oe_any = 1;
      sck_i = 1;
      repeat (6) @(negedge clk);
    end
    csn_i = 1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] tx, ext, seen, got, first;
    logic cs_ok, oe_all, oe_any;
    int per;
    int seed;
    seed = $urandom(32'h0005_17AB);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tdre", tdre, 1); chk("R1 rdrf", rdrf, 0); chk("R1 ovr", ovr, 0);
    chk("R1 sck_o", sck_o, 1); chk("R1 csn_o", csn_o, 1);
    chk("R1 data oe", {a_oe, b_oe}, 0); chk("R1 bus oe", {sck_oe, csn_oe}, 0);

    // Standard master, full duplex
    wr_mode(0, 1); wr_en(1, 1);
    chk("R2 sck_oe master", sck_oe, 1);
    for (int k = 0; k < 6; k++) begin
      tx  = (k == 0) ? 8'h80 : (k == 1) ? 8'h01 : DW'($urandom);
      ext = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : DW'($urandom);
      wr_tdr(tx);
      master_byte(ext, exp_rx_on_b(0, 1), exp_tx_on_b(0, 1), seen, cs_ok, oe_all, oe_any, per);
      chk("R2 R6 tx bits on A msb first", seen, tx);
      chk("R2 a_oe during byte", oe_all, 1);
      chk("R7 csn low at every rise", cs_ok, 1);
      chk("R7 csn high after byte", csn_o, 1);
      chk("R6 sck period", per, 2 * HALF);
      chk("R12 tdre after start", tdre, 1);
      chk("R2 rdrf after byte", rdrf, 1);
      rd_rdr(got);
      chk("R2 rx bits from B", got, ext);
      chk("R12 read clears rdrf", rdrf, 0);
    end

    // Overrun, then receive disable keeps state
    first = 8'hA5;
    wr_tdr(8'h3C);
    master_byte(first, 1, 0, seen, cs_ok, oe_all, oe_any, per);
    wr_tdr(8'hC3);
    master_byte(8'h5A, 1, 0, seen, cs_ok, oe_all, oe_any, per);
    chk("R11 ovr set", ovr, 1);
    chk("R11 rdr kept", rdr_q, first);
    wr_en(1, 0);
    chk("R9 rdrf kept", rdrf, 1); chk("R9 ovr kept", ovr, 1); chk("R9 rdr kept", rdr_q, first);
    clr_ovr();
    chk("R13 ovr cleared", ovr, 0);
    wr_en(0, 0);
    rd_rdr(got);
    chk("R12 rdrf cleared", rdrf, 0);

    // Standard slave
    wr_mode(0, 0);
    chk("R3 slave bus oe", {sck_oe, csn_oe}, 0);
    wr_en(1, 1);
    wr_mode(0, 1);
    chk("R10 mode write ignored", sck_oe, 0);
    for (int k = 0; k < 4; k++) begin
      tx = DW'($urandom); ext = DW'($urandom);
      wr_tdr(tx);
      slave_byte(ext, exp_rx_on_b(0, 0), exp_tx_on_b(0, 0), seen, oe_any);
      chk("R3 tx bits on B", seen, tx);
      chk("R3 b_oe while selected", oe_any, 1);
      chk("R3 a_oe quiet", a_oe, 0);
      rd_rdr(got);
      chk("R3 rx bits from A", got, ext);
    end

    // Transmit-enable clearing
    wr_tdr(8'h77);
    chk("R12 write clears tdre", tdre, 0);
    wr_en(0, 0);
    chk("R8 tx off sets tdre", tdre, 1);
    wr_tdr(8'h11);
    chk("R8 write with tx off", tdre, 1);

    // Shared-line master, transmit only
    wr_mode(1, 1); wr_en(1, 0);
    tx = DW'($urandom);
    wr_tdr(tx);
    master_byte(8'h00, 0, 0, seen, cs_ok, oe_all, oe_any, per);
    chk("R4 tx on A", seen, tx);
    chk("R5 a_oe during tx", oe_all, 1);
    chk("R5 a_oe after tx", a_oe, 0);
    chk("R4 b_oe quiet", b_oe, 0);

    // Shared-line master, receive only
    wr_en(0, 1);
    ext = DW'($urandom);
    master_byte(ext, 0, 0, seen, cs_ok, oe_all, oe_any, per);
    chk("R5 no drive on rx", oe_any, 0);
    repeat (20) @(negedge clk);
    chk("R12 no start while full", csn_o, 1);
    wr_en(0, 0);
    rd_rdr(got);
    chk("R4 rx from A", got, ext);

    // Shared-line master, both enabled: transmit only
    wr_en(1, 1);
    tx = DW'($urandom);
    wr_tdr(tx);
    master_byte(DW'($urandom), 0, 0, seen, cs_ok, oe_all, oe_any, per);
    chk("R5 tx wins", seen, tx);
    chk("R5 no capture", rdrf, 0);
    wr_en(0, 0);

    // Shared-line slave, receive
    wr_mode(1, 0); wr_en(0, 1);
    ext = DW'($urandom);
    slave_byte(ext, 0, 0, seen, oe_any);
    chk("R5 slave rx no drive", oe_any, 0);
    rd_rdr(got);
    chk("R4 slave rx from A", got, ext);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule